// File: doc/BRIEF.md
# NOR flash command state machine

This block is the command interface and embedded-algorithm controller of a small boot-sector NOR flash. The host reaches it through chip-enable, write-enable and output-enable strobes, all active low. The block samples them on its own clock. A write cycle is taken on the rising edge of write-enable while chip-enable is low, and the address and data are latched at that moment. Multi-cycle unlock sequences are decoded into program, sector erase, chip erase, unlock-bypass, suspend and resume requests. A controller then runs them against an internal word-wide array model. Program length comes from a cycle-count parameter, and erase is a walker that visits every array word.

An erase runs in two passes over the selected sectors. The first pass drives every selected word to zero and the second sets it to all ones. While an operation runs, reads return a status word instead of array data, and the ready output is low. A sector lock input vector blocks program and erase on chosen sectors. A temporary-unprotect input overrides those locks while it is high. A sector erase can be suspended to read or program other sectors, and then resumed. The active-low hardware reset aborts any operation and returns the block to reading array data.

The sector map scales with the address width. One unit is 2^(ADDR_W-5) words, which is 64 words at the default ADDR_W of 11. Sectors 0 to 6 span 2, 1, 1, 4, 8, 8 and 8 units, starting at address 0. At the default width their start addresses are 0, 128, 192, 256, 512, 1024 and 1536.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: A program is four writes: 0xAA to word address 0x555, 0x55 to 0x2AA, 0xA0 to 0x555, then the target address and data. When the operation ends, the target word holds the old word ANDed with the data.
- R2: The writes 0xAA/0x555, 0x55/0x2AA and 0x20/0x555 enter a bypass mode. In that mode a program takes two writes: 0xA0 at any address, then the target address and data.
- R3: While a program runs, bit 7 of every read is the complement of bit 7 of the data being programmed, and bit 6 inverts between successive reads.
- R4: The ready output is high after reset, goes low in the cycle after a program or erase is accepted, and returns high when that operation ends.
- R5: Driving the hardware reset low aborts a running program. The target word keeps its old value and the ready output is high.
- R6: A sector erase clears exactly the address range of the sector named by its final write, as the map above gives. Words on either side of each boundary keep their contents.
- R7: A program or erase aimed at a sector whose lock bit is set is refused. Ready stays high and the array is unchanged. While the temporary-unprotect input is high, every lock is ignored.
- R8: Writing 0xB0 during a sector erase suspends it, and ready goes high. Other sectors can then be read and programmed. Writing 0x30 resumes the erase, and the erase then finishes with its sector all ones.
- R9: Sector erase is 0xAA/0x555, 0x55/0x2AA, 0x80/0x555, 0xAA/0x555, 0x55/0x2AA, then 0x30 at any address in the sector. Ending the sequence with 0x10 to 0x555 instead erases every unlocked sector to all ones.
- R10: A write that breaks an unlock sequence returns the block to read mode. That write and any write after it that is not part of a valid sequence leave the array unchanged.
- R11: Program only clears bits. A program never turns a 0 bit into a 1.
- R12: While a program or erase runs, writes other than 0xB0 are ignored and reads return the status word. In the status word, bit 7 follows R3 during a program, reads 0 during a running erase and reads 1 during a suspend. Bit 6 is the toggle bit, bit 3 is 1 while an erase is pending, and all other bits are 0. During a suspend, reads of the erasing sector also return the status word.
- R13: Writing 0xF0 at any step of a command sequence, other than the program data cycle, returns the block to read mode. This includes leaving bypass mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; a write is taken on its rising edge |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Write data |
| dout | output | 16 | Read data or status word |
| dout_oe | output | 1 | High while a read cycle is active |
| rdy_busy_n | output | 1 | High when ready, low while an operation runs |
| prot_lock | input | 7 | Per-sector lock bits, bit k for sector k |
| unprot_tmp | input | 1 | Overrides all locks while high |

## Verification
A command decoder stuck in the wrong step shows up at the next command: the program or erase that should start leaves ready high, or a stray write changes array contents that a later read exposes. A wrong controller state is visible within one read cycle. Ready would fail to drop, the status word would carry the wrong bit 7 or a frozen bit 6, or a suspended erase would leave its sector unerased after resume. A wrong sector decode marks its boundary words after the next sector erase: a read just inside or just outside the sector returns the wrong value.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
   localparam int NSECT = 7;
   localparam int SW    = 3;

   typedef enum logic [3:0] {
      C_READ, C_UL1, C_UL2, C_PGM, C_ER3, C_ER4, C_ER5, C_BYP, C_BPGM
   } cmd_st_t;

   typedef enum logic [2:0] {
      E_IDLE, E_PROG, E_ERASE, E_SUSP, E_SPROG
   } alg_st_t;

   localparam logic [7:0]  K_UL1  = 8'hAA;
   localparam logic [7:0]  K_UL2  = 8'h55;
   localparam logic [7:0]  K_PGM  = 8'hA0;
   localparam logic [7:0]  K_ERS  = 8'h80;
   localparam logic [7:0]  K_BYP  = 8'h20;
   localparam logic [7:0]  K_RST  = 8'hF0;
   localparam logic [7:0]  K_SEC  = 8'h30;
   localparam logic [7:0]  K_CHIP = 8'h10;
   localparam logic [7:0]  K_SUSP = 8'hB0;
   localparam logic [10:0] UA1    = 11'h555;
   localparam logic [10:0] UA2    = 11'h2AA;

   // start of sector k in map units; k == NSECT gives the array end
   function automatic int unsigned sect_units(input int k);
      case (k)
         0:       return 0;
         1:       return 2;
         2:       return 3;
         3:       return 4;
         4:       return 8;
         5:       return 16;
         6:       return 24;
         default: return 32;
      endcase
   endfunction
endpackage

// File: rtl/nfc_sect_dec.sv
module nfc_sect_dec
   import nfc_pkg::*;
#(
   parameter int ADDR_W = 11
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [SW-1:0]     idx
);
   localparam int USH = ADDR_W - 5;

   logic [NSECT-1:0] hit;

   for (genvar k = 0; k < NSECT; k++) begin : g_win
      localparam int unsigned LO = sect_units(k) << USH;
      localparam int unsigned HI = sect_units(k + 1) << USH;
      assign hit[k] = (32'(addr) >= LO) && (32'(addr) < HI);
   end

   always_comb begin
      idx = '0;
      for (int k = 0; k < NSECT; k++) begin
         if (hit[k]) idx = SW'(k);
      end
   end
endmodule

// File: rtl/nfc_cmd_seq.sv
module nfc_cmd_seq
   import nfc_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_stb,
   input  logic [10:0] wr_addr,
   input  logic [7:0]  wr_code,
   input  logic        busy_run,
   input  logic        susp_act,
   output logic        go_prog,
   output logic        go_se,
   output logic        go_ce,
   output logic        susp_req,
   output logic        res_req
);
   cmd_st_t st, nxt;
   logic    at1, at2;

   assign at1 = (wr_addr == UA1);
   assign at2 = (wr_addr == UA2);

   always_comb begin
      nxt      = st;
      go_prog  = 1'b0;
      go_se    = 1'b0;
      go_ce    = 1'b0;
      susp_req = 1'b0;
      res_req  = 1'b0;
      if (wr_stb) begin
         if (busy_run) begin
            susp_req = (wr_code == K_SUSP);
         end else if (wr_code == K_RST && st != C_PGM && st != C_BPGM) begin
            nxt = C_READ;
         end else begin
            case (st)
               C_READ: begin
                  if (wr_code == K_UL1 && at1) nxt = C_UL1;
                  else if (susp_act && wr_code == K_SEC) res_req = 1'b1;
               end
               C_UL1: nxt = (wr_code == K_UL2 && at2) ? C_UL2 : C_READ;
               C_UL2: begin
                  nxt = C_READ;
                  if (at1) begin
                     case (wr_code)
                        K_PGM:   nxt = C_PGM;
                        K_ERS:   nxt = C_ER3;
                        K_BYP:   nxt = C_BYP;
                        default: nxt = C_READ;
                     endcase
                  end
               end
               C_PGM: begin
                  go_prog = 1'b1;
                  nxt     = C_READ;
               end
               C_ER3: nxt = (wr_code == K_UL1 && at1) ? C_ER4 : C_READ;
               C_ER4: nxt = (wr_code == K_UL2 && at2) ? C_ER5 : C_READ;
               C_ER5: begin
                  nxt = C_READ;
                  if (wr_code == K_SEC) go_se = !susp_act;
                  else if (wr_code == K_CHIP && at1) go_ce = !susp_act;
               end
               C_BYP: if (wr_code == K_PGM) nxt = C_BPGM;
               C_BPGM: begin
                  go_prog = 1'b1;
                  nxt     = C_BYP;
               end
               default: nxt = C_READ;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= C_READ;
      else        st <= nxt;
   end

   // R12: sequence position frozen while an operation runs
   p_busy_ignores_wr_r12: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run |=> $stable(st));
endmodule

// File: rtl/nfc_algo.sv
module nfc_algo
   import nfc_pkg::*;
#(
   parameter int ADDR_W   = 11,
   parameter int PROG_CYC = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_prog,
   input  logic              go_se,
   input  logic              go_ce,
   input  logic              susp_req,
   input  logic              res_req,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [SW-1:0]     bus_sect,
   input  logic [15:0]       wr_data,
   input  logic [NSECT-1:0]  lk,
   input  logic              rd_start,
   output logic [15:0]       rd_word,
   output logic              ready,
   output logic              busy_run,
   output logic              susp_act
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int CW    = $clog2(PROG_CYC + 1);

   if (PROG_CYC < 2) begin : g_chk_cyc
      $error("PROG_CYC must be at least 2");
   end

   alg_st_t           st;
   logic [CW-1:0]     pcnt;
   logic [ADDR_W-1:0] paddr, ptr;
   logic [15:0]       pdata, sw;
   logic [SW-1:0]     psect, ptr_sect;
   logic [NSECT-1:0]  emask;
   logic              echip, ephase, tog;
   logic              pgm_st, prog_done, susp_now, step_en, running, prog_ok, stat_sel;
   logic [15:0]       mem [DEPTH];

   nfc_sect_dec #(.ADDR_W(ADDR_W)) u_walk_dec (.addr(ptr), .idx(ptr_sect));

   assign pgm_st    = (st == E_PROG) || (st == E_SPROG);
   assign prog_done = pgm_st && (pcnt == CW'(PROG_CYC - 1));
   assign susp_now  = (st == E_ERASE) && susp_req && !echip;
   assign step_en   = (st == E_ERASE) && !susp_now;
   assign running   = pgm_st || (st == E_ERASE);
   assign prog_ok   = go_prog && !lk[bus_sect];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= E_IDLE;
         pcnt   <= '0;
         paddr  <= '0;
         pdata  <= '0;
         psect  <= '0;
         emask  <= '0;
         echip  <= 1'b0;
         ephase <= 1'b0;
         ptr    <= '0;
         tog    <= 1'b0;
      end else begin
         if (rd_start && running) tog <= ~tog;
         if (pgm_st) pcnt <= pcnt + 1'b1;
         case (st)
            E_IDLE: begin
               if (prog_ok) begin
                  st    <= E_PROG;
                  pcnt  <= '0;
                  paddr <= bus_addr;
                  pdata <= wr_data;
                  psect <= bus_sect;
               end else if (go_se && !lk[bus_sect]) begin
                  emask  <= NSECT'(1) << bus_sect;
                  echip  <= 1'b0;
                  ephase <= 1'b0;
                  ptr    <= '0;
                  st     <= E_ERASE;
               end else if (go_ce && (~lk != '0)) begin
                  emask  <= ~lk;
                  echip  <= 1'b1;
                  ephase <= 1'b0;
                  ptr    <= '0;
                  st     <= E_ERASE;
               end
            end
            E_PROG:  if (prog_done) st <= E_IDLE;
            E_SPROG: if (prog_done) st <= E_SUSP;
            E_ERASE: begin
               if (susp_now) begin
                  st <= E_SUSP;
               end else begin
                  ptr <= ptr + 1'b1;
                  if (&ptr) begin
                     if (ephase) begin
                        st    <= E_IDLE;
                        emask <= '0;
                     end else begin
                        ephase <= 1'b1;
                     end
                  end
               end
            end
            E_SUSP: begin
               if (res_req) begin
                  st <= E_ERASE;
               end else if (prog_ok && !emask[bus_sect]) begin
                  st    <= E_SPROG;
                  pcnt  <= '0;
                  paddr <= bus_addr;
                  pdata <= wr_data;
                  psect <= bus_sect;
               end
            end
            default: st <= E_IDLE;
         endcase
      end
   end

   // array model: program lands at the end of its window, erase walks words
   always_ff @(posedge clk) begin
      if (prog_done)
         mem[paddr] <= mem[paddr] & pdata;
      else if (step_en && emask[ptr_sect])
         mem[ptr] <= {16{ephase}};
   end

   always_comb begin
      sw    = '0;
      sw[7] = pgm_st ? ~pdata[7] : (st == E_SUSP);
      sw[6] = tog;
      sw[3] = (st == E_ERASE) || (st == E_SUSP) || (st == E_SPROG);
   end

   assign stat_sel = running || ((st == E_SUSP) && emask[bus_sect]);
   assign rd_word  = stat_sel ? sw : mem[bus_addr];
   assign ready    = !running;
   assign busy_run = running;
   assign susp_act = (st == E_SUSP);

   // R4: an accepted program drops ready on the next cycle
   p_busy_after_go_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == E_IDLE && go_prog && !lk[bus_sect]) |=> !ready);

   // R7: a locked target never starts an operation
   p_lock_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == E_IDLE && (go_prog || go_se) && lk[bus_sect]) |=> (st == E_IDLE));

   // R3: each read during a running operation flips the toggle bit
   p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_start && running) |=> (tog != $past(tog)));

   // R8: a program under suspend never lands in the erasing sector
   p_susp_outside_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_done && st == E_SPROG) |-> !emask[psect]);
endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
   import nfc_pkg::*;
#(
   parameter int ADDR_W   = 11,
   parameter int PROG_CYC = 20,
   parameter bit DOUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [15:0]       din,
   output logic [15:0]       dout,
   output logic              dout_oe,
   output logic              rdy_busy_n,
   input  logic [NSECT-1:0]  prot_lock,
   input  logic              unprot_tmp
);
   if (ADDR_W < 11 || ADDR_W > 16) begin : g_chk_aw
      $error("ADDR_W must lie in 11..16");
   end

   logic             we_q, rd_q, wr_stb, rd_on, rd_start;
   logic             go_prog, go_se, go_ce, susp_req, res_req;
   logic             busy_run, susp_act, ready;
   logic [SW-1:0]    bus_sect;
   logic [NSECT-1:0] lk;
   logic [15:0]      rd_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q <= 1'b1;
         rd_q <= 1'b0;
      end else begin
         we_q <= we_n;
         rd_q <= rd_on;
      end
   end

   assign wr_stb   = we_n && !we_q && !ce_n;
   assign rd_on    = !ce_n && !oe_n && we_n;
   assign rd_start = rd_on && !rd_q;
   assign lk       = prot_lock & {NSECT{!unprot_tmp}};

   nfc_sect_dec #(.ADDR_W(ADDR_W)) u_bus_dec (.addr(addr), .idx(bus_sect));

   nfc_cmd_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb   (wr_stb),
      .wr_addr  (addr[10:0]),
      .wr_code  (din[7:0]),
      .busy_run (busy_run),
      .susp_act (susp_act),
      .go_prog  (go_prog),
      .go_se    (go_se),
      .go_ce    (go_ce),
      .susp_req (susp_req),
      .res_req  (res_req)
   );

   nfc_algo #(.ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC)) u_algo (
      .clk      (clk),
      .rst_n    (rst_n),
      .go_prog  (go_prog),
      .go_se    (go_se),
      .go_ce    (go_ce),
      .susp_req (susp_req),
      .res_req  (res_req),
      .bus_addr (addr),
      .bus_sect (bus_sect),
      .wr_data  (din),
      .lk       (lk),
      .rd_start (rd_start),
      .rd_word  (rd_word),
      .ready    (ready),
      .busy_run (busy_run),
      .susp_act (susp_act)
   );

   assign rdy_busy_n = ready;

   if (DOUT_REG) begin : g_dout_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dout    <= '0;
            dout_oe <= 1'b0;
         end else begin
            dout    <= rd_word;
            dout_oe <= rd_on;
         end
      end
   end else begin : g_dout_comb
      assign dout    = rd_word;
      assign dout_oe = rd_on;
   end

   // R4: a completed write strobe while idle never leaves ready low without cause
   p_ready_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !go_prog && !go_se && !go_ce && !res_req) |=> rdy_busy_n);
endmodule

// File: tb/nor_cmd_ctrl_tb_top.sv
module nor_cmd_ctrl_tb_top;
   localparam int CLK_P  = 10;
   localparam int AW     = 11;
   localparam int PCYC   = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [15:0]   din = '0;
   logic [15:0]   dout;
   logic          dout_oe, rdy_busy_n;
   logic [6:0]    prot_lock = '0;
   logic          unprot_tmp = 1'b0;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   nor_cmd_ctrl #(.ADDR_W(AW), .PROG_CYC(PCYC)) dut_i (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
      .rdy_busy_n(rdy_busy_n), .prot_lock(prot_lock), .unprot_tmp(unprot_tmp)
   );

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic bus_wr(input logic [AW-1:0] a, input logic [15:0] d);
      @(negedge clk); addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
      @(negedge clk); we_n = 1'b1;
      @(negedge clk); ce_n = 1'b1;
   endtask

   task automatic bus_rd(input logic [AW-1:0] a, output logic [15:0] d);
      @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
      @(negedge clk);
      @(negedge clk); d = dout; ce_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic unlock;
      bus_wr(11'h555, 16'h00AA);
      bus_wr(11'h2AA, 16'h0055);
   endtask

   task automatic do_prog(input logic [AW-1:0] a, input logic [15:0] d);
      unlock();
      bus_wr(11'h555, 16'h00A0);
      bus_wr(a, d);
   endtask

   task automatic do_erase(input logic [AW-1:0] a, input bit chip);
      unlock();
      bus_wr(11'h555, 16'h0080);
      unlock();
      if (chip) bus_wr(11'h555, 16'h0010);
      else      bus_wr(a, 16'h0030);
   endtask

   task automatic wait_ready(input string tag);
      int n = 0;
      while (!rdy_busy_n && n < 20000) begin
         @(negedge clk);
         n++;
      end
      chk(tag, 16'(rdy_busy_n), 16'h1);
   endtask

   task automatic t_reset_state;
      chk("R4 ready after reset", 16'(rdy_busy_n), 16'h1);
      chk("R4 no read after reset", 16'(dout_oe), 16'h0);
   endtask

   task automatic t_chip_erase;
      logic [15:0] v;
      do_erase('0, 1'b1);
      chk("R4 busy during chip erase", 16'(rdy_busy_n), 16'h0);
      bus_rd(11'd40, v);
      chk("R12 erase status word", v & 16'hFFBF, 16'h0008);
      wait_ready("R9 chip erase ends");
      bus_rd(11'd0, v);    chk("R9 chip erase low word", v, 16'hFFFF);
      bus_rd(11'd2047, v); chk("R9 chip erase top word", v, 16'hFFFF);
   endtask

   task automatic t_program;
      logic [15:0] v1, v2;
      do_prog(11'd10, 16'h0F0F);
      chk("R4 busy during program", 16'(rdy_busy_n), 16'h0);
      bus_rd(11'd10, v1);
      bus_rd(11'd10, v2);
      chk("R3 polling bit", 16'(v1[7]), 16'h1);
      chk("R12 status word fields", v1 & 16'hFFBF, 16'h0080);
      chk("R3 toggle bit", 16'(v1[6] ^ v2[6]), 16'h1);
      wait_ready("R4 program ends");
      bus_rd(11'd10, v1); chk("R1 program result", v1, 16'h0F0F);
      do_prog(11'd10, 16'h00FF);
      wait_ready("R11 second program ends");
      bus_rd(11'd10, v1); chk("R11 bits only cleared", v1, 16'h000F);
   endtask

   task automatic t_bypass;
      logic [15:0] v;
      unlock();
      bus_wr(11'h555, 16'h0020);
      bus_wr(11'd7, 16'h00A0);
      bus_wr(11'd20, 16'h1234);
      wait_ready("R2 bypass program ends");
      bus_rd(11'd20, v); chk("R2 bypass program", v, 16'h1234);
      bus_wr(11'd3, 16'h00A0);
      bus_wr(11'd21, 16'hABCD);
      wait_ready("R2 second bypass program ends");
      bus_rd(11'd21, v); chk("R2 second bypass program", v, 16'hABCD);
      bus_wr(11'd0, 16'h00F0);
      bus_wr(11'd3, 16'h00A0);
      bus_wr(11'd22, 16'h0000);
      chk("R13 no program after exit", 16'(rdy_busy_n), 16'h1);
      bus_rd(11'd22, v); chk("R13 word untouched after exit", v, 16'hFFFF);
   endtask

   task automatic t_broken;
      logic [15:0] v;
      unlock();
      bus_wr(11'h555, 16'h0012);
      bus_wr(11'd30, 16'h0000);
      chk("R10 ready after broken sequence", 16'(rdy_busy_n), 16'h1);
      bus_rd(11'd30, v); chk("R10 word after broken sequence", v, 16'hFFFF);
      bus_wr(11'h554, 16'h00AA);
      bus_wr(11'h2AA, 16'h0055);
      bus_wr(11'h555, 16'h00A0);
      bus_wr(11'd31, 16'h0000);
      bus_rd(11'd31, v); chk("R10 wrong unlock address", v, 16'hFFFF);
      unlock();
      bus_wr(11'h555, 16'h00F0);
      bus_wr(11'h555, 16'h00A0);
      bus_wr(11'd32, 16'h0000);
      bus_rd(11'd32, v); chk("R13 reset code mid sequence", v, 16'hFFFF);
   endtask

   task automatic t_hw_reset;
      logic [15:0] v;
      do_prog(11'd5, 16'h0000);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
      chk("R5 ready after abort", 16'(rdy_busy_n), 16'h1);
      bus_rd(11'd5, v); chk("R5 word kept after abort", v, 16'hFFFF);
   endtask

   task automatic t_sector_map;
      logic [15:0] v;
      do_prog(11'd127, 16'h1234); wait_ready("R6 prep 127");
      do_prog(11'd128, 16'h1234); wait_ready("R6 prep 128");
      do_prog(11'd191, 16'h1234); wait_ready("R6 prep 191");
      do_prog(11'd192, 16'h1234); wait_ready("R6 prep 192");
      do_erase(11'd150, 1'b0);
      chk("R9 busy during sector erase", 16'(rdy_busy_n), 16'h0);
      wait_ready("R9 sector erase ends");
      bus_rd(11'd127, v); chk("R6 word below sector", v, 16'h1234);
      bus_rd(11'd128, v); chk("R6 first word of sector", v, 16'hFFFF);
      bus_rd(11'd191, v); chk("R6 last word of sector", v, 16'hFFFF);
      bus_rd(11'd192, v); chk("R6 word above sector", v, 16'h1234);
   endtask

   task automatic t_lock;
      logic [15:0] v;
      prot_lock = 7'b0000100;
      unprot_tmp = 1'b1;
      do_prog(11'd200, 16'h00FF);
      wait_ready("R7 unprotected program ends");
      bus_rd(11'd200, v); chk("R7 temporary unprotect", v, 16'h00FF);
      unprot_tmp = 1'b0;
      do_prog(11'd200, 16'h0000);
      chk("R7 locked program refused", 16'(rdy_busy_n), 16'h1);
      bus_rd(11'd200, v); chk("R7 locked word after program", v, 16'h00FF);
      do_erase(11'd200, 1'b0);
      chk("R7 locked erase refused", 16'(rdy_busy_n), 16'h1);
      bus_rd(11'd200, v); chk("R7 locked word after erase", v, 16'h00FF);
      prot_lock = '0;
   endtask

   task automatic t_suspend;
      logic [15:0] v;
      do_prog(11'd300, 16'h00F0); wait_ready("R8 prep 300");
      do_prog(11'd1100, 16'h0000); wait_ready("R8 prep 1100");
      do_erase(11'd1100, 1'b0);
      repeat (20) @(negedge clk);
      bus_wr(11'd0, 16'h00B0);
      chk("R8 ready while suspended", 16'(rdy_busy_n), 16'h1);
      bus_rd(11'd300, v); chk("R8 read other sector", v, 16'h00F0);
      bus_rd(11'd1100, v); chk("R12 erasing sector gives status", v & 16'hFFBF, 16'h0088);
      do_prog(11'd600, 16'h0F0F);
      wait_ready("R8 program under suspend ends");
      bus_rd(11'd600, v); chk("R8 program under suspend", v, 16'h0F0F);
      bus_wr(11'd0, 16'h0030);
      chk("R8 busy after resume", 16'(rdy_busy_n), 16'h0);
      wait_ready("R8 resumed erase ends");
      bus_rd(11'd1100, v); chk("R8 erased after resume", v, 16'hFFFF);
      bus_rd(11'd1535, v); chk("R8 sector end erased", v, 16'hFFFF);
      bus_rd(11'd600, v);  chk("R8 other sector kept", v, 16'h0F0F);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_chip_erase();
      t_program();
      t_bypass();
      t_broken();
      t_hw_reset();
      t_sector_map();
      t_lock();
      t_suspend();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_P * 190000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R4 actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule